// File: doc/BRIEF.md
# Repeated String Operation Sequencer

This block runs one x86-style string instruction (OUTS, INS, MOVS, LODS, STOS, SCAS or CMPS) at byte, word or dword width. It loops over the elements, with or without a repeat prefix. The caller supplies the operation, the element size, the prefix bits, the direction flag, the source index, destination index, count, accumulator and I/O port number, plus a per-invocation cycle budget. The block then issues memory and I/O transactions one element at a time. It hands back the merged register values, the accumulator, the compare flags, a restart request and a fault indication.

A single invocation may stop before the whole count is consumed. Three things can end it early: a per-invocation element cap, an exhausted budget, or a memory fault. The write-back is built so that re-running the same instruction continues where the previous run left off. Only the index and count bits that belong to the active address size are replaced. Segment bases are outside the block. Memory requests carry an offset and a flag that says whether the destination (DI) side is addressed.

Top module: `strop_seq`

## Requirements
- R1: With `addr32`=0 the indices and count use only their low 16 bits, and index stepping wraps within 16 bits (0x0000 minus one gives 0xFFFF). With `addr32`=1 all 32 bits are used.
- R2: After each element, each index the operation uses moves by 1, 2 or 4 for size code 0, 1 or 2. It increments when `dir`=0 and decrements when `dir`=1.
- R3: Without a repeat prefix exactly one element is processed and `cx_out` equals `cx_in`.
- R4: With a repeat prefix and a masked count of zero, no memory or I/O transaction is issued and `restart` is 0.
- R5: At most REP_CAP elements are processed per invocation (REP_CAP=0 means no cap). The excess stays in the written-back count.
- R6: Each element uses one unit of budget. After the element that brings the budget to zero or below, the run ends. A budget of 0 or 1 therefore gives exactly one element.
- R7: SCAS (op 5) compares the accumulator with memory at DI. CMPS (op 6) compares memory at SI with memory at DI. The run ends after an element whose equality differs from `rep_z`. ZF, CF (borrow), SF and OF come from the subtraction first-operand minus second-operand of the last pair, taken at the element size.
- R8: Bits of SI, DI and CX above the address size keep their input values. CX is rewritten only under a repeat prefix.
- R9: `restart` is 1 when a repeat prefix is present, no fault occurred and the remaining count is nonzero. For SCAS and CMPS, ZF must also equal `rep_z`.
- R10: A memory fault ends the run. The faulting element is not counted and does not step the indices. `fault`=1 and `restart`=0.
- R11: Op codes are OUTS=0, INS=1, MOVS=2, LODS=3, STOS=4, SCAS=5 and CMPS=6. OUTS sends memory at SI to I/O port `dx_in`. INS stores I/O data at DI. MOVS copies SI to DI. LODS replaces only the low element-size bits of the accumulator. STOS writes the accumulator's low bits to DI.
- R12: At most one of `mem_req` and `io_req` is high at a time. A request and its address stay unchanged until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an invocation (taken when idle) |
| op | input | 3 | Operation code (R11) |
| size | input | 2 | Element size: 0 byte, 1 word, 2 dword |
| rep | input | 1 | Repeat prefix present |
| rep_z | input | 1 | Repeat condition: 1 repeat-while-equal, 0 repeat-while-not-equal |
| addr32 | input | 1 | 32-bit address size |
| dir | input | 1 | Direction: 1 decrements |
| si_in | input | 32 | Source index |
| di_in | input | 32 | Destination index |
| cx_in | input | 32 | Count register |
| acc_in | input | 32 | Accumulator |
| dx_in | input | 16 | I/O port number |
| budget | input | BUDGET_W | Cycle budget for this invocation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write |
| mem_dseg | output | 1 | Request addresses the destination side |
| mem_addr | output | 32 | Memory offset |
| mem_size | output | 2 | Transfer size |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Memory acknowledge |
| mem_fault | input | 1 | Acknowledged transaction faulted |
| mem_rdata | input | 32 | Read data |
| io_req | output | 1 | I/O request |
| io_we | output | 1 | I/O write |
| io_port | output | 16 | I/O port number |
| io_size | output | 2 | I/O transfer size |
| io_wdata | output | 32 | I/O write data |
| io_ready | input | 1 | I/O acknowledge |
| io_rdata | input | 32 | I/O read data |
| busy | output | 1 | Invocation in progress |
| done | output | 1 | One-cycle end of invocation; results valid from here until next start |
| si_out | output | 32 | Written-back source index |
| di_out | output | 32 | Written-back destination index |
| cx_out | output | 32 | Written-back count |
| acc_out | output | 32 | Accumulator after the run |
| flag_zf | output | 1 | Zero flag of last compare |
| flag_cf | output | 1 | Borrow flag of last compare |
| flag_sf | output | 1 | Sign flag of last compare |
| flag_of | output | 1 | Overflow flag of last compare |
| flags_valid | output | 1 | A compare element completed in this run |
| restart | output | 1 | Re-run the same instruction |
| fault | output | 1 | Run ended by a memory fault |

## Verification
The assertions assume that `mem_ready` and `io_ready` come only while the matching request is high, and that `mem_fault` is high only together with `mem_ready`. They also assume `start` arrives only while the block is idle. The stimulus follows these rules: a responder raises acknowledge for one cycle in response to a pending request, a fault is attached only to a chosen acknowledge, and each operation is launched only after the previous `done`. All addresses used stay inside the bench's modelled memory window, so wrap and merge effects show up only through the register outputs.

// File: rtl/strop_pkg.sv
package strop_pkg;

  typedef enum logic [2:0] {
    OP_OUTS = 3'd0,
    OP_INS  = 3'd1,
    OP_MOVS = 3'd2,
    OP_LODS = 3'd3,
    OP_STOS = 3'd4,
    OP_SCAS = 3'd5,
    OP_CMPS = 3'd6
  } strop_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XA,
    ST_XB,
    ST_STEP,
    ST_FIN
  } seq_st_e;

  // index width selected by the address-size prefix
  function automatic logic [31:0] addr_mask(input logic a32);
    return a32 ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // bits of one element
  function automatic logic [31:0] elem_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // signed stride as a two's complement addend
  function automatic logic [31:0] elem_step(input logic dec, input logic [1:0] sz);
    logic [31:0] mag;
    mag = (sz >= 2'd2) ? 32'd4 : (32'd1 << sz);
    return dec ? (~mag + 32'd1) : mag;
  endfunction

  // replace the selected bits of a register
  function automatic logic [31:0] merge_bits(input logic [31:0] keep,
                                             input logic [31:0] fresh,
                                             input logic [31:0] sel);
    return (keep & ~sel) | (fresh & sel);
  endfunction

endpackage

// File: rtl/strop_flags.sv
module strop_flags (
  input  logic [31:0] lhs,
  input  logic [31:0] rhs,
  input  logic [1:0]  sz,
  output logic        zf,
  output logic        cf,
  output logic        sf,
  output logic        of
);
  import strop_pkg::*;

  logic [31:0] m;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] diff;
  logic        sa, sb, sd;

  always_comb begin
    m    = elem_mask(sz);
    a    = lhs & m;
    b    = rhs & m;
    diff = (a - b) & m;
    case (sz)
      2'd0:    begin sa = a[7];  sb = b[7];  sd = diff[7];  end
      2'd1:    begin sa = a[15]; sb = b[15]; sd = diff[15]; end
      default: begin sa = a[31]; sb = b[31]; sd = diff[31]; end
    endcase
    zf = (diff == 32'd0);
    cf = (a < b);
    sf = sd;
    of = (sa != sb) && (sd != sa);
  end

endmodule

// File: rtl/strop_wb.sv
module strop_wb (
  input  logic [31:0] si_orig,
  input  logic [31:0] si_cur,
  input  logic [31:0] di_orig,
  input  logic [31:0] di_cur,
  input  logic [31:0] cx_orig,
  input  logic [31:0] cnt_rem,
  input  logic [31:0] amask,
  input  logic        rep_on,
  output logic [31:0] si_out,
  output logic [31:0] di_out,
  output logic [31:0] cx_out
);
  import strop_pkg::*;

  assign si_out = merge_bits(si_orig, si_cur, amask);
  assign di_out = merge_bits(di_orig, di_cur, amask);
  assign cx_out = rep_on ? merge_bits(cx_orig, cnt_rem, amask) : cx_orig;

endmodule

// File: rtl/strop_seq.sv
module strop_seq #(
  parameter int REP_CAP  = 0,
  parameter int BUDGET_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [2:0]          op,
  input  logic [1:0]          size,
  input  logic                rep,
  input  logic                rep_z,
  input  logic                addr32,
  input  logic                dir,
  input  logic [31:0]         si_in,
  input  logic [31:0]         di_in,
  input  logic [31:0]         cx_in,
  input  logic [31:0]         acc_in,
  input  logic [15:0]         dx_in,
  input  logic [BUDGET_W-1:0] budget,
  output logic                mem_req,
  output logic                mem_we,
  output logic                mem_dseg,
  output logic [31:0]         mem_addr,
  output logic [1:0]          mem_size,
  output logic [31:0]         mem_wdata,
  input  logic                mem_ready,
  input  logic                mem_fault,
  input  logic [31:0]         mem_rdata,
  output logic                io_req,
  output logic                io_we,
  output logic [15:0]         io_port,
  output logic [1:0]          io_size,
  output logic [31:0]         io_wdata,
  input  logic                io_ready,
  input  logic [31:0]         io_rdata,
  output logic                busy,
  output logic                done,
  output logic [31:0]         si_out,
  output logic [31:0]         di_out,
  output logic [31:0]         cx_out,
  output logic [31:0]         acc_out,
  output logic                flag_zf,
  output logic                flag_cf,
  output logic                flag_sf,
  output logic                flag_of,
  output logic                flags_valid,
  output logic                restart,
  output logic                fault
);
  import strop_pkg::*;

  localparam logic [31:0]         CAP_V  = 32'(REP_CAP);
  localparam logic                CAP_ON = (REP_CAP > 0);
  localparam logic [BUDGET_W-1:0] B_ONE  = BUDGET_W'(1);

  seq_st_e             st;
  strop_e              op_q;
  logic [1:0]          sz_q;
  logic                rep_q, repz_q, dec_q;
  logic [31:0]         mask_q, si0_q, di0_q, cx0_q;
  logic [31:0]         si_q, di_q, cnt_q, left_q;
  logic [BUDGET_W-1:0] bud_q;
  logic [31:0]         acc_q, data_a_q, lhs_q, rhs_q;
  logic [15:0]         dx_q;
  logic                cmp_seen_q, fault_q;

  // named internal events
  logic        xfer_ack, xfer_fault, elem_fire, is_cmp, has_second;
  logic        uses_si, uses_di, stop_now, cmp_eq;
  logic [31:0] dmask, rd_data, stride, start_cnt, rem_cnt;

  assign dmask      = elem_mask(sz_q);
  assign stride     = elem_step(dec_q, sz_q);
  assign is_cmp     = (op_q == OP_SCAS) || (op_q == OP_CMPS);
  assign has_second = (op_q == OP_OUTS) || (op_q == OP_INS) ||
                      (op_q == OP_MOVS) || (op_q == OP_CMPS);
  assign uses_si    = (op_q == OP_OUTS) || (op_q == OP_MOVS) ||
                      (op_q == OP_LODS) || (op_q == OP_CMPS);
  assign uses_di    = (op_q == OP_INS)  || (op_q == OP_MOVS) || (op_q == OP_STOS) ||
                      (op_q == OP_SCAS) || (op_q == OP_CMPS);
  assign start_cnt  = rep ? (cx_in & addr_mask(addr32)) : 32'd1;
  assign rem_cnt    = cnt_q + left_q;

  // one transaction per state, request held until acknowledged
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_dseg  = 1'b0;
    mem_addr  = si_q;
    mem_wdata = acc_q & dmask;
    io_req    = 1'b0;
    io_we     = 1'b0;
    io_wdata  = data_a_q;
    if (st == ST_XA) begin
      case (op_q)
        OP_INS:  io_req = 1'b1;
        OP_STOS: begin mem_req = 1'b1; mem_we = 1'b1; mem_dseg = 1'b1; mem_addr = di_q; end
        OP_SCAS: begin mem_req = 1'b1; mem_dseg = 1'b1; mem_addr = di_q; end
        default: mem_req = 1'b1;
      endcase
    end else if (st == ST_XB) begin
      case (op_q)
        OP_OUTS: begin io_req = 1'b1; io_we = 1'b1; end
        OP_CMPS: begin mem_req = 1'b1; mem_dseg = 1'b1; mem_addr = di_q; end
        default: begin
          mem_req = 1'b1; mem_we = 1'b1; mem_dseg = 1'b1;
          mem_addr = di_q; mem_wdata = data_a_q;
        end
      endcase
    end
  end

  assign xfer_ack   = (mem_req && mem_ready && !mem_fault) || (io_req && io_ready);
  assign xfer_fault = mem_req && mem_ready && mem_fault;
  assign elem_fire  = (st == ST_STEP);
  assign rd_data    = (io_req ? io_rdata : mem_rdata) & dmask;
  assign stop_now   = (cnt_q == 32'd1) || (bud_q <= B_ONE) || (is_cmp && (cmp_eq != repz_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE;        op_q <= OP_OUTS;     sz_q <= 2'd0;
      rep_q <= 1'b0;        repz_q <= 1'b0;      dec_q <= 1'b0;
      mask_q <= 32'd0;      si0_q <= 32'd0;      di0_q <= 32'd0;
      cx0_q <= 32'd0;       si_q <= 32'd0;       di_q <= 32'd0;
      cnt_q <= 32'd0;       left_q <= 32'd0;     bud_q <= '0;
      acc_q <= 32'd0;       data_a_q <= 32'd0;   lhs_q <= 32'd0;
      rhs_q <= 32'd0;       dx_q <= 16'd0;       cmp_seen_q <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          op_q <= strop_e'(op);  sz_q <= size;  rep_q <= rep;
          repz_q <= rep_z;  dec_q <= dir;  mask_q <= addr_mask(addr32);
          si0_q <= si_in;  di0_q <= di_in;  cx0_q <= cx_in;
          si_q <= si_in & addr_mask(addr32);
          di_q <= di_in & addr_mask(addr32);
          acc_q <= acc_in;  dx_q <= dx_in;  bud_q <= budget;
          cmp_seen_q <= 1'b0;  fault_q <= 1'b0;
          if (CAP_ON && (start_cnt > CAP_V)) begin
            cnt_q <= CAP_V;  left_q <= start_cnt - CAP_V;
          end else begin
            cnt_q <= start_cnt;  left_q <= 32'd0;
          end
          st <= (start_cnt == 32'd0) ? ST_FIN : ST_XA;
        end
        ST_XA: begin
          if (xfer_fault) begin
            fault_q <= 1'b1;  st <= ST_FIN;
          end else if (xfer_ack) begin
            data_a_q <= rd_data;
            if (op_q == OP_LODS) acc_q <= merge_bits(acc_q, rd_data, dmask);
            if (op_q == OP_SCAS) begin lhs_q <= acc_q & dmask; rhs_q <= rd_data; end
            st <= has_second ? ST_XB : ST_STEP;
          end
        end
        ST_XB: begin
          if (xfer_fault) begin
            fault_q <= 1'b1;  st <= ST_FIN;
          end else if (xfer_ack) begin
            if (op_q == OP_CMPS) begin lhs_q <= data_a_q; rhs_q <= rd_data; end
            st <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (uses_si) si_q <= (si_q + stride) & mask_q;
          if (uses_di) di_q <= (di_q + stride) & mask_q;
          cnt_q <= cnt_q - 32'd1;
          bud_q <= (bud_q <= B_ONE) ? '0 : bud_q - B_ONE;
          cmp_seen_q <= is_cmp;
          st <= stop_now ? ST_FIN : ST_XA;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  strop_flags u_flags (
    .lhs(lhs_q), .rhs(rhs_q), .sz(sz_q),
    .zf(cmp_eq), .cf(flag_cf), .sf(flag_sf), .of(flag_of)
  );

  strop_wb u_wb (
    .si_orig(si0_q), .si_cur(si_q), .di_orig(di0_q), .di_cur(di_q),
    .cx_orig(cx0_q), .cnt_rem(rem_cnt), .amask(mask_q), .rep_on(rep_q),
    .si_out(si_out), .di_out(di_out), .cx_out(cx_out)
  );

  assign flag_zf     = cmp_eq;
  assign flags_valid = cmp_seen_q;
  assign acc_out     = acc_q;
  assign mem_size    = sz_q;
  assign io_size     = sz_q;
  assign io_port     = dx_q;
  assign busy        = (st != ST_IDLE);
  assign done        = (st == ST_FIN);
  assign fault       = fault_q;
  assign restart     = done && rep_q && !fault_q && (rem_cnt != 32'd0) &&
                       (!is_cmp || (cmp_eq == repz_q));

  // R12: never a memory and an I/O request together
  p_one_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && io_req));
  // R12: pending memory request keeps its address
  p_hold_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));
  // R1: working indices never carry bits outside the address size
  p_idx_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (((si_q | di_q) & ~mask_q) == 32'd0));
  // R5: the per-invocation count never exceeds the cap
  p_cap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!CAP_ON || (cnt_q <= CAP_V)));
  // R4: zero repeat count goes straight to completion
  p_zero_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && rep && ((cx_in & addr_mask(addr32)) == 32'd0)) |=> (done && !mem_req && !io_req));
  // R10: a fault ends the run without counting the element
  p_fault_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fault |=> (done && fault && (cnt_q == $past(cnt_q))));

endmodule

// File: tb/strop_seq_bench.sv
module strop_seq_bench;
  localparam int CLK_T = 10;
  localparam int CAP   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] op = 3'd0;
  logic [1:0] size = 2'd0;
  logic rep = 1'b0, rep_z = 1'b0, addr32 = 1'b1, dir = 1'b0;
  logic [31:0] si_in = 0, di_in = 0, cx_in = 0, acc_in = 0;
  logic [15:0] dx_in = 0;
  logic [15:0] budget = 16'd100;
  logic mem_req, mem_we, mem_dseg;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0] mem_size, io_size;
  logic mem_ready = 1'b0, mem_fault = 1'b0;
  logic [31:0] mem_rdata = 0;
  logic io_req, io_we;
  logic [15:0] io_port;
  logic [31:0] io_wdata;
  logic io_ready = 1'b0;
  logic [31:0] io_rdata = 0;
  logic busy, done, flag_zf, flag_cf, flag_sf, flag_of, flags_valid, restart, fault;
  logic [31:0] si_out, di_out, cx_out, acc_out;

  always #(CLK_T/2) clk = ~clk;

  strop_seq #(.REP_CAP(CAP), .BUDGET_W(16)) u_strop_seq (.*);

  int total = 0, bad = 0;
  logic [7:0] mem [0:255];
  int mtx = 0, fault_at = 0, both_cnt = 0, ndone = 0, cyc = 0;
  logic [31:0] io_val = 0, io_last_data = 0;
  logic [15:0] io_last_port = 0;

  typedef struct {
    logic [31:0] si, di, cx, acc;
    logic rs, flt;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  function automatic int bix(logic ds, logic [31:0] a, int k);
    return (ds ? 128 : 0) + int'((a + 32'(k)) & 32'd127);
  endfunction

  function automatic int nbytes(logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // responder: acknowledge one cycle after a pending request
  always @(negedge clk) begin
    if (mem_req && !mem_ready) begin
      logic [31:0] w;
      w = 0;
      for (int k = 0; k < nbytes(mem_size); k++) w[8*k +: 8] = mem[bix(mem_dseg, mem_addr, k)];
      mem_rdata <= w;
      mem_ready <= 1'b1;
      mem_fault <= (fault_at != 0) && (mtx + 1 == fault_at);
    end else begin
      mem_ready <= 1'b0;
      mem_fault <= 1'b0;
    end
    if (io_req && !io_ready) begin
      io_ready <= 1'b1;
      io_rdata <= io_val;
    end else io_ready <= 1'b0;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && io_req) both_cnt <= both_cnt + 1;
    if (mem_req && mem_ready) begin
      mtx <= mtx + 1;
      if (mem_we && !mem_fault)
        for (int k = 0; k < nbytes(mem_size); k++)
          mem[bix(mem_dseg, mem_addr, k)] <= mem_wdata[8*k +: 8];
    end
    if (io_req && io_ready && io_we) begin
      io_last_port <= io_port;
      io_last_data <= io_wdata;
    end
  end

  // monitor: pop the expected item at each completion
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb_q.size() == 0) chk(1'b0, "R9 unexpected done", 0, 0);
      else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(si_out == e.si, {e.tag, " si"}, si_out, e.si);
        chk(di_out == e.di, {e.tag, " di"}, di_out, e.di);
        chk(cx_out == e.cx, {e.tag, " cx"}, cx_out, e.cx);
        chk(acc_out == e.acc, {e.tag, " acc"}, acc_out, e.acc);
        chk(restart == e.rs, {e.tag, " restart"}, 32'(restart), 32'(e.rs));
        chk(fault == e.flt, {e.tag, " fault"}, 32'(fault), 32'(e.flt));
      end
      ndone++;
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic run_op(input logic [2:0] o, input logic [1:0] s, input logic r, input logic rz,
                        input logic a32, input logic d, input logic [31:0] si, input logic [31:0] di,
                        input logic [31:0] cx, input logic [31:0] acc, input logic [15:0] bud,
                        input exp_t e);
    int n0, w;
    sb_q.push_back(e);
    n0 = ndone;
    @(negedge clk);
    op = o; size = s; rep = r; rep_z = rz; addr32 = a32; dir = d;
    si_in = si; di_in = di; cx_in = cx; acc_in = acc; budget = bud; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    w = 0;
    while (ndone == n0 && w < 2000) begin @(negedge clk); w++; end
    if (ndone == n0) chk(1'b0, {e.tag, " timeout"}, 32'(w), 0);
    @(negedge clk);
  endtask

  initial begin
    exp_t e;
    int m0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && mem_req == 0 && io_req == 0, "reset idle", {busy, done, mem_req, io_req}, 0);
    rst_n = 1'b1;

    // R2 R8 R11: MOVSB, 16-bit address, upper bits kept
    mem[16] = 8'h11; mem[17] = 8'h22; mem[18] = 8'h33;
    e = '{32'hABCD0013, 32'h00AB0023, 32'h55550000, 32'h0, 1'b0, 1'b0, "R8 movsb"};
    run_op(3'd2, 2'd0, 1, 0, 0, 0, 32'hABCD0010, 32'h00AB0020, 32'h55550003, 0, 100, e);
    chk(mem[128+32] == 8'h11 && mem[128+34] == 8'h33, "R11 movsb data", {mem[128+32], mem[128+34]}, 32'h1133);

    // R2: STOSW decrementing by two
    e = '{32'h5, 32'h3C, 32'h0, 32'h1234BEEF, 1'b0, 1'b0, "R2 stosw"};
    run_op(3'd4, 2'd1, 1, 0, 1, 1, 32'h5, 32'h40, 32'h2, 32'h1234BEEF, 100, e);
    chk(mem[128+62] == 8'hEF && mem[128+65] == 8'hBE, "R2 stosw data", {mem[128+62], mem[128+65]}, 32'hEFBE);

    // R3: LODSD without prefix
    mem[80] = 8'h01; mem[81] = 8'h02; mem[82] = 8'h03; mem[83] = 8'h04;
    e = '{32'h54, 32'h9, 32'h77, 32'h04030201, 1'b0, 1'b0, "R3 lodsd"};
    run_op(3'd3, 2'd2, 0, 0, 1, 0, 32'h50, 32'h9, 32'h77, 0, 100, e);

    // R11: LODSB merges only the low byte
    e = '{32'h52, 32'h9, 32'h0, 32'hAABBCC02, 1'b0, 1'b0, "R11 lodsb"};
    run_op(3'd3, 2'd0, 1, 0, 1, 0, 32'h51, 32'h9, 32'h1, 32'hAABBCCDD, 100, e);

    // R4: zero masked count
    m0 = mtx;
    e = '{32'h10, 32'h20, 32'hFFFF0000, 32'h0, 1'b0, 1'b0, "R4 zero"};
    run_op(3'd2, 2'd0, 1, 0, 0, 0, 32'h10, 32'h20, 32'hFFFF0000, 0, 100, e);
    chk(mtx == m0, "R4 no transfers", 32'(mtx - m0), 0);

    // R5 R9: cap of six
    e = '{32'h0, 32'h66, 32'h4, 32'h77, 1'b1, 1'b0, "R5 cap"};
    run_op(3'd4, 2'd0, 1, 0, 1, 0, 32'h0, 32'h60, 32'hA, 32'h77, 100, e);

    // R6: budget of two
    e = '{32'h0, 32'h72, 32'h3, 32'h77, 1'b1, 1'b0, "R6 budget"};
    run_op(3'd4, 2'd0, 1, 0, 1, 0, 32'h0, 32'h70, 32'h5, 32'h77, 2, e);

    // R1: 16-bit wrap and 32-bit borrow
    mem[0] = 8'h9C;
    e = '{32'h1234FFFF, 32'h0, 32'h0, 32'h9C, 1'b0, 1'b0, "R1 wrap16"};
    run_op(3'd3, 2'd0, 0, 0, 0, 1, 32'h12340000, 32'h0, 32'h0, 0, 100, e);
    e = '{32'h1233FFFF, 32'h0, 32'h0, 32'h9C, 1'b0, 1'b0, "R1 wrap32"};
    run_op(3'd3, 2'd0, 0, 0, 1, 1, 32'h12340000, 32'h0, 32'h0, 0, 100, e);

    // R7 R9: repeat-while-equal scan stops on mismatch
    mem[128+8] = 8'h41; mem[128+9] = 8'h41; mem[128+10] = 8'h42; mem[128+11] = 8'h41;
    e = '{32'h0, 32'hB, 32'h1, 32'h41, 1'b0, 1'b0, "R7 scasb"};
    run_op(3'd5, 2'd0, 1, 1, 1, 0, 32'h0, 32'h8, 32'h4, 32'h41, 100, e);
    chk(flag_zf == 0 && flag_cf == 1 && flag_sf == 1 && flag_of == 0 && flags_valid == 1,
        "R7 flags", {flag_zf, flag_cf, flag_sf, flag_of, flags_valid}, 5'b01101);

    // R7: repeat-while-not-equal compare stops on match
    mem[48] = 1; mem[49] = 2; mem[50] = 3;
    mem[128+48] = 5; mem[128+49] = 6; mem[128+50] = 3;
    e = '{32'h33, 32'h33, 32'h2, 32'h0, 1'b0, 1'b0, "R7 cmpsb"};
    run_op(3'd6, 2'd0, 1, 0, 1, 0, 32'h30, 32'h30, 32'h5, 0, 100, e);
    chk(flag_zf == 1, "R7 cmps zf", 32'(flag_zf), 1);

    // R9: compare run cut by cap restarts
    for (int i = 8; i < 14; i++) mem[128+i] = 8'h41;
    e = '{32'h0, 32'hE, 32'h4, 32'h41, 1'b1, 1'b0, "R9 scas restart"};
    run_op(3'd5, 2'd0, 1, 1, 1, 0, 32'h0, 32'h8, 32'hA, 32'h41, 100, e);

    // R11: OUTSW and INSB
    mem[68] = 8'hFE; mem[69] = 8'hCA;
    dx_in = 16'h03F8;
    e = '{32'h46, 32'h0, 32'h0, 32'h0, 1'b0, 1'b0, "R11 outsw"};
    run_op(3'd0, 2'd1, 0, 0, 1, 0, 32'h44, 32'h0, 32'h0, 0, 100, e);
    chk(io_last_port == 16'h03F8 && io_last_data == 32'h0000CAFE, "R11 outsw io", io_last_data, 32'hCAFE);
    io_val = 32'hFFFFFF5A;
    e = '{32'h0, 32'h51, 32'h0, 32'h0, 1'b0, 1'b0, "R11 insb"};
    run_op(3'd1, 2'd0, 0, 0, 1, 0, 32'h0, 32'h50, 32'h0, 0, 100, e);
    chk(mem[128+80] == 8'h5A, "R11 insb data", 32'(mem[128+80]), 32'h5A);

    // R10: fault on the third store
    fault_at = mtx + 3;
    e = '{32'h0, 32'h2, 32'h3, 32'h66, 1'b0, 1'b1, "R10 fault"};
    run_op(3'd4, 2'd0, 1, 0, 1, 0, 32'h0, 32'h0, 32'h5, 32'h66, 100, e);
    fault_at = 0;
    chk(mem[128+2] != 8'h66, "R10 faulted byte unwritten", 32'(mem[128+2]), 0);

    chk(both_cnt == 0, "R12 single request", 32'(both_cnt), 0);
    chk(sb_q.size() == 0, "R9 scoreboard drained", 32'(sb_q.size()), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule